// File: doc/BRIEF.md
# Sub-Word Register File with Size-Matched Forwarding

This block holds a bank of 64-bit registers that an execution pipeline writes with results of 8, 16, 32 or 64 bits. A sized write replaces only the low chunk of the target register and leaves the bits above it as they were. A write flagged as SIMD replaces the whole word whatever its size code. Every result waits for one cycle in a single pending slot before it is merged into the array. For each register the block keeps four zero flags, one for each chunk size. These flags are recomputed from the full merged word each time a write lands.

Two read ports ask for an operand of a given size. If the pending result targets the register being read and was written at that same size, the block forwards it to the reader. If the sizes differ, the block does not build a mixed word from the pending result and the old register value. It raises `stall` for the one cycle in which the pending write commits. The reader repeats its read in the next cycle and gets the merged value and its flag straight from the array. This keeps the merge logic out of the forwarding path, at the price of one bubble on a size change.

Top module: `rfb_subword_regfile`

## Requirements
- R1: After reset every register reads as zero with its zero flag set for every size, and `stall` is low.
- R2: A write without SIMD updates only the low chunk that its size code selects (00 = 8, 01 = 16, 10 = 32, 11 = 64 bits) and leaves all bits above that chunk unchanged.
- R3: A write with SIMD set replaces the whole 64-bit register whatever its size code. For forwarding it counts as size code 11.
- R4: `rdN_zero` is high exactly when the low chunk of the requested size of the value the port returns is zero. Flags are recomputed from the full merged register after every write.
- R5: A write accepted at a clock edge lands in the array at the next edge. A read of a register with no pending write returns the array value without a stall.
- R6: When an enabled port reads the register of the pending write at the same effective size, the port returns the pending data word with no stall.
- R7: When an enabled port reads the register of the pending write at a different effective size, `stall` is high for that one cycle. In the next cycle the same read returns the merged value and flag with no stall.
- R8: A port whose enable is low never causes a stall. Either port alone can cause one.
- R9: Back-to-back writes to one register accumulate: the second merges onto the result of the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 4 | Destination register |
| wr_size | input | 2 | Chunk size code of the result |
| wr_simd | input | 1 | Whole-word write regardless of size |
| wr_data | input | 64 | Result word |
| rd0_en | input | 1 | Port 0 read request |
| rd0_addr | input | 4 | Port 0 register |
| rd0_size | input | 2 | Port 0 operand size code |
| rd0_data | output | 64 | Port 0 operand |
| rd0_zero | output | 1 | Port 0 zero flag for the requested size |
| rd1_en | input | 1 | Port 1 read request |
| rd1_addr | input | 4 | Port 1 register |
| rd1_size | input | 2 | Port 1 operand size code |
| rd1_data | output | 64 | Port 1 operand |
| rd1_zero | output | 1 | Port 1 zero flag for the requested size |
| stall | output | 1 | Reader must retry next cycle |

## Verification
The hardest case to reach is a read that hits the pending slot. It only exists in the single cycle between the edge that accepts a write and the edge that commits it, so the read must be issued in exactly that window. The stimulus first preloads the target register with a full-width background pattern. It then issues the sized write and drives the read one cycle later, inside the window. There it checks either forwarding or a stall, and one cycle after that it checks the merged word and the flags for every size. A back-to-back pair of writes covers merging onto a register whose previous value has itself only just landed.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

   // Chunk size codes; the numeric order is used for lane selection.
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_DWORD = 2'b11
   } chunk_sz_e;

   localparam int CHUNK_KINDS = 4;
   localparam int READ_PORTS  = 2;

endpackage

// File: rtl/rfb_chunk_mask.sv
module rfb_chunk_mask #(
   parameter int DATA_W = 64
) (
   input  logic [1:0]        size,
   input  logic              simd,
   output logic [DATA_W-1:0] mask
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int LANE = (b < DATA_W/8) ? 0 :
                            (b < DATA_W/4) ? 1 :
                            (b < DATA_W/2) ? 2 : 3;
      assign mask[b] = simd | (size >= LANE[1:0]);
   end

endmodule

// File: rtl/rfb_zero_detect.sv
module rfb_zero_detect #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]                 data,
   output logic [rfb_pkg::CHUNK_KINDS-1:0]   zf
);

   for (genvar k = 0; k < rfb_pkg::CHUNK_KINDS; k++) begin : g_lane
      localparam int CW = DATA_W >> (rfb_pkg::CHUNK_KINDS - 1 - k);
      assign zf[k] = ~|data[CW-1:0];
   end

endmodule

// File: rtl/rfb_read_port.sv
module rfb_read_port #(
   parameter int DATA_W = 64,
   parameter int AW     = 4
) (
   input  logic                            rd_en,
   input  logic [AW-1:0]                   rd_addr,
   input  logic [1:0]                      rd_size,
   input  logic                            pend_vld,
   input  logic [AW-1:0]                   pend_addr,
   input  logic [1:0]                      pend_eff_size,
   input  logic [DATA_W-1:0]               pend_data,
   input  logic [rfb_pkg::CHUNK_KINDS-1:0] pend_zf,
   input  logic [DATA_W-1:0]               arr_data,
   input  logic [rfb_pkg::CHUNK_KINDS-1:0] arr_zf,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            rd_zero,
   output logic                            hazard
);

   logic hit;
   logic same_size;
   logic fwd;

   assign hit       = rd_en & pend_vld & (rd_addr == pend_addr);
   assign same_size = (rd_size == pend_eff_size);
   assign fwd       = hit & same_size;
   assign hazard    = hit & ~same_size;

   always_comb begin
      if (fwd) begin
         rd_data = pend_data;
         rd_zero = pend_zf[rd_size];
      end else begin
         rd_data = arr_data;
         rd_zero = arr_zf[rd_size];
      end
   end

endmodule

// File: rtl/rfb_subword_regfile.sv
module rfb_subword_regfile #(
   parameter int DATA_W = 64,
   parameter int NREGS  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [$clog2(NREGS)-1:0]  wr_addr,
   input  logic [1:0]                wr_size,
   input  logic                      wr_simd,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      rd0_en,
   input  logic [$clog2(NREGS)-1:0]  rd0_addr,
   input  logic [1:0]                rd0_size,
   output logic [DATA_W-1:0]         rd0_data,
   output logic                      rd0_zero,
   input  logic                      rd1_en,
   input  logic [$clog2(NREGS)-1:0]  rd1_addr,
   input  logic [1:0]                rd1_size,
   output logic [DATA_W-1:0]         rd1_data,
   output logic                      rd1_zero,
   output logic                      stall
);
   import rfb_pkg::*;

   localparam int AW = $clog2(NREGS);
   localparam int NP = READ_PORTS;
   localparam int ZW = CHUNK_KINDS;

   // Elaboration-time parameter checks
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (NREGS < 2 || (1 << AW) != NREGS) begin : g_bad_depth
      $error("NREGS must be a power of two, at least 2");
   end

   // Register array and per-size zero flags
   logic [DATA_W-1:0] regs_q [NREGS];
   logic [ZW-1:0]     zf_q   [NREGS];

   // Pending write slot
   logic              pend_vld;
   logic [AW-1:0]     pend_addr;
   logic [1:0]        pend_size;
   logic              pend_simd;
   logic [DATA_W-1:0] pend_data;
   logic [1:0]        pend_eff_size;
   logic [ZW-1:0]     pend_zf;

   assign pend_eff_size = pend_simd ? 2'(SZ_DWORD) : pend_size;

   // Commit path: merge pending chunk onto the stored word
   logic [DATA_W-1:0] commit_mask;
   logic [DATA_W-1:0] commit_old;
   logic [DATA_W-1:0] commit_word;
   logic [ZW-1:0]     commit_zf;

   rfb_chunk_mask #(.DATA_W(DATA_W)) u_mask (
      .size (pend_size),
      .simd (pend_simd),
      .mask (commit_mask)
   );

   assign commit_old  = regs_q[pend_addr];
   assign commit_word = (commit_old & ~commit_mask) | (pend_data & commit_mask);

   rfb_zero_detect #(.DATA_W(DATA_W)) u_commit_zd (
      .data (commit_word),
      .zf   (commit_zf)
   );

   // Zero flags of the raw pending word, used when forwarding
   rfb_zero_detect #(.DATA_W(DATA_W)) u_pend_zd (
      .data (pend_data),
      .zf   (pend_zf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_addr <= '0;
         pend_size <= 2'(SZ_BYTE);
         pend_simd <= 1'b0;
         pend_data <= '0;
         for (int r = 0; r < NREGS; r++) begin
            regs_q[r] <= '0;
            zf_q[r]   <= '1;
         end
      end else begin
         pend_vld <= wr_en;
         if (wr_en) begin
            pend_addr <= wr_addr;
            pend_size <= wr_size;
            pend_simd <= wr_simd;
            pend_data <= wr_data;
         end
         if (pend_vld) begin
            regs_q[pend_addr] <= commit_word;
            zf_q[pend_addr]   <= commit_zf;
         end
      end
   end

   // Read ports
   logic              rp_en     [NP];
   logic [AW-1:0]     rp_addr   [NP];
   logic [1:0]        rp_size   [NP];
   logic [DATA_W-1:0] rp_data   [NP];
   logic              rp_zero   [NP];
   logic [NP-1:0]     rp_hazard;

   assign rp_en[0]   = rd0_en;
   assign rp_addr[0] = rd0_addr;
   assign rp_size[0] = rd0_size;
   assign rp_en[1]   = rd1_en;
   assign rp_addr[1] = rd1_addr;
   assign rp_size[1] = rd1_size;

   for (genvar p = 0; p < NP; p++) begin : g_port
      rfb_read_port #(.DATA_W(DATA_W), .AW(AW)) u_port (
         .rd_en         (rp_en[p]),
         .rd_addr       (rp_addr[p]),
         .rd_size       (rp_size[p]),
         .pend_vld      (pend_vld),
         .pend_addr     (pend_addr),
         .pend_eff_size (pend_eff_size),
         .pend_data     (pend_data),
         .pend_zf       (pend_zf),
         .arr_data      (regs_q[rp_addr[p]]),
         .arr_zf        (zf_q[rp_addr[p]]),
         .rd_data       (rp_data[p]),
         .rd_zero       (rp_zero[p]),
         .hazard        (rp_hazard[p])
      );
   end

   assign rd0_data = rp_data[0];
   assign rd0_zero = rp_zero[0];
   assign rd1_data = rp_data[1];
   assign rd1_zero = rp_zero[1];
   assign stall    = |rp_hazard;

endmodule

// File: rtl/rfb_subword_regfile_chk.sv
module rfb_subword_regfile_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd0_en,
   input logic [1:0]        rd0_size,
   input logic [DATA_W-1:0] rd0_data,
   input logic              rd0_zero,
   input logic              rd1_en,
   input logic [1:0]        rd1_size,
   input logic [DATA_W-1:0] rd1_data,
   input logic              rd1_zero,
   input logic              stall,
   input logic              pend_vld
);

   function automatic logic [DATA_W-1:0] low_mask(input logic [1:0] s);
      int w;
      w = DATA_W >> (3 - int'(s));
      return {DATA_W{1'b1}} >> (DATA_W - w);
   endfunction

   AST_ZERO_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_en && !stall) |-> (rd0_zero == ((rd0_data & low_mask(rd0_size)) == '0))); // R4

   AST_ZERO_PORT1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd1_en && !stall) |-> (rd1_zero == ((rd1_data & low_mask(rd1_size)) == '0))); // R4

   AST_NO_PEND_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_vld |-> !stall); // R5

   AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !wr_en) |=> !stall); // R7

   AST_IDLE_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd0_en && !rd1_en) |-> !stall); // R8

endmodule

bind rfb_subword_regfile rfb_subword_regfile_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd0_en   (rd0_en),
   .rd0_size (rd0_size),
   .rd0_data (rd0_data),
   .rd0_zero (rd0_zero),
   .rd1_en   (rd1_en),
   .rd1_size (rd1_size),
   .rd1_data (rd1_data),
   .rd1_zero (rd1_zero),
   .stall    (stall),
   .pend_vld (pend_vld)
);

// File: tb/rfb_subword_regfile_bench.sv
`timescale 1ns/1ps
module rfb_subword_regfile_bench;

   localparam int DW = 64;
   localparam int NR = 16;
   localparam int AW = 4;
   localparam int NV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [1:0]    wr_size = '0;
   logic          wr_simd = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd0_en = 1'b0;
   logic [AW-1:0] rd0_addr = '0;
   logic [1:0]    rd0_size = '0;
   logic [DW-1:0] rd0_data;
   logic          rd0_zero;
   logic          rd1_en = 1'b0;
   logic [AW-1:0] rd1_addr = '0;
   logic [1:0]    rd1_size = '0;
   logic [DW-1:0] rd1_data;
   logic          rd1_zero;
   logic          stall;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rfb_subword_regfile #(.DATA_W(DW), .NREGS(NR)) u_rfb_subword_regfile (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_simd(wr_simd), .wr_data(wr_data),
      .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_zero(rd0_zero),
      .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_zero(rd1_zero),
      .stall(stall)
   );

   // Vector fields: background, write data, write size, simd, read size
   localparam logic [132:0] VEC [NV] = '{
      {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 2'd0, 1'b0, 2'd0},
      {64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_0000, 2'd1, 1'b0, 2'd1},
      {64'hFFFF_0000_FFFF_FFFF, 64'h1111_2222_0000_0000, 2'd2, 1'b0, 2'd0},
      {64'h0000_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00D, 2'd3, 1'b0, 2'd3},
      {64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_0000, 2'd0, 1'b1, 2'd3},
      {64'h5555_5555_5555_5555, 64'h1234_0000_0000_0000, 2'd1, 1'b1, 2'd1},
      {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0100, 2'd0, 1'b0, 2'd3},
      {64'h00FF_0000_0000_0000, 64'h0000_0000_0000_0000, 2'd2, 1'b0, 2'd2}
   };

   function automatic logic [DW-1:0] size_mask(input logic [1:0] s);
      return {DW{1'b1}} >> (DW - (8 << s));
   endfunction

   function automatic logic [DW-1:0] model_merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                                 input logic [1:0] s, input logic simd);
      logic [DW-1:0] m;
      m = simd ? {DW{1'b1}} : size_mask(s);
      return (old & ~m) | (nw & m);
   endfunction

   function automatic logic model_zero(input logic [DW-1:0] v, input logic [1:0] s);
      return (v & size_mask(s)) == '0;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Present a write for one edge; returns at the next falling edge with it pending.
   task automatic do_write(input logic [AW-1:0] a, input logic [1:0] s, input logic simd,
                           input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_size = s; wr_simd = simd; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd0_en = 1'b1; rd0_addr = 4'd0;  rd0_size = 2'd3;
      rd1_en = 1'b1; rd1_addr = 4'd15; rd1_size = 2'd0;
      #1;
      check("R1 data0", rd0_data, '0);
      check("R1 zero0", 64'(rd0_zero), 64'd1);
      check("R1 data1", rd1_data, '0);
      check("R1 zero1", 64'(rd1_zero), 64'd1);
      check("R1 stall", 64'(stall), 64'd0);
      rd0_en = 1'b0; rd1_en = 1'b0;

      // Table walk: R2 R3 R4 R6 R7
      for (int i = 0; i < NV; i++) begin
         logic [63:0] bg, wd, mg;
         logic [1:0]  ws, rs;
         logic        sm, fwd;
         logic [AW-1:0] a;
         {bg, wd, ws, sm, rs} = VEC[i];
         a   = AW'(i + 2);
         mg  = model_merge(bg, wd, ws, sm);
         fwd = ((sm ? 2'd3 : ws) == rs);
         do_write(a, 2'd3, 1'b0, bg);
         @(negedge clk);
         do_write(a, ws, sm, wd);
         rd0_en = 1'b1; rd0_addr = a; rd0_size = rs;
         #1;
         if (fwd) begin
            check("R6 stall", 64'(stall), 64'd0);
            check("R6 data", rd0_data, wd);
            check("R6 zero", 64'(rd0_zero), 64'(model_zero(wd, rs)));
         end else begin
            check("R7 stall", 64'(stall), 64'd1);
         end
         @(negedge clk);
         #1;
         check("R7 after", 64'(stall), 64'd0);
         check(sm ? "R3 merged" : "R2 merged", rd0_data, mg);
         check("R4 zero", 64'(rd0_zero), 64'(model_zero(mg, rs)));
         rd1_en = 1'b1; rd1_addr = a;
         for (int k = 0; k < 4; k++) begin
            rd1_size = 2'(k);
            #1;
            check("R4 flag", 64'(rd1_zero), 64'(model_zero(mg, 2'(k))));
         end
         rd0_en = 1'b0; rd1_en = 1'b0;
      end

      // R5: other register read while a write is pending
      do_write(4'd12, 2'd3, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F);
      @(negedge clk);
      do_write(4'd12, 2'd0, 1'b0, 64'h0000_0000_0000_00AA);
      rd0_en = 1'b1; rd0_addr = 4'd13; rd0_size = 2'd2;
      #1;
      check("R5 stall", 64'(stall), 64'd0);
      check("R5 data", rd0_data, '0);
      rd0_en = 1'b0;
      @(negedge clk);
      rd0_en = 1'b1; rd0_addr = 4'd12; rd0_size = 2'd3;
      #1;
      check("R5 landed", rd0_data, 64'h0F0F_0F0F_0F0F_0FAA);
      rd0_en = 1'b0;

      // R8: disabled port never stalls; port 1 alone stalls
      do_write(4'd12, 2'd1, 1'b0, 64'h0000_0000_0000_1234);
      rd0_addr = 4'd12; rd0_size = 2'd0; rd0_en = 1'b0;
      #1;
      check("R8 disabled", 64'(stall), 64'd0);
      rd1_en = 1'b1; rd1_addr = 4'd12; rd1_size = 2'd3;
      #1;
      check("R8 port1", 64'(stall), 64'd1);
      rd1_en = 1'b0;
      @(negedge clk);

      // R9: back-to-back writes accumulate
      do_write(4'd14, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd14; wr_size = 2'd1; wr_simd = 1'b0; wr_data = 64'h0000_0000_0000_AAAA;
      @(negedge clk);
      wr_size = 2'd0; wr_data = 64'h0000_0000_0000_0055;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      rd0_en = 1'b1; rd0_addr = 4'd14; rd0_size = 2'd3;
      #1;
      check("R9 data", rd0_data, 64'hFFFF_FFFF_FFFF_AA55);
      check("R9 stall", 64'(stall), 64'd0);
      rd0_en = 1'b0;

      @(negedge clk);
      finish_run();
   end

endmodule